// File: doc/BRIEF.md
# Event Timer-Counter with Hidden Prescaler

This block is a timer-counter peripheral clocked by the system clock. It advances either on every system clock (timer mode) or on a chosen edge of an asynchronous external input (counter mode). The external input passes through a synchroniser and an edge detector. The count is 8 or 16 bits wide, chosen by a control bit. A power-of-two prescaler can sit in the count path. Software cannot see the prescaler, but it is reset whenever software commits a new count.

Software uses a byte-wide register port with four addresses. Address 0 is the count low byte, address 1 is the count high byte, address 2 is the control register and address 3 is the status register. When the selected width rolls over to zero, the block sets a sticky flag. The interrupt output is that flag gated by an enable bit. In 16-bit mode, high-byte writes and high-byte reads go through holding buffers, so that software sees the two bytes as one 16-bit value.

Top module: `evt_timer`

## Requirements
- R1: After reset, the following read as zero: the count, the control register, the high-byte read latch and the status register (flag and enable). The interrupt output is low.
- R2: In timer mode (control bit 0 = 0) the count source is the system clock.
  - With the prescaler assigned (control bit 2 = 0) and ratio field n (control bits 5:3), the count advances once every 2^(n+1) clocks.
  - With the prescaler bypassed (control bit 2 = 1), the count advances on every clock.
- R3: In counter mode (control bit 0 = 1), edge select (control bit 1) picks the edge that counts: 0 counts rising edges and 1 counts falling edges. The opposite edge is ignored. The count read at address 0 changes three clocks after the pin changes. With the prescaler assigned, edges are divided by the selected ratio.
- R4: A write to address 0 commits a new count.
  - The commit takes priority over an increment in the same cycle.
  - No increment occurs on the two clocks after the commit.
  - If the prescaler is assigned, the commit also clears it, so the first increment comes 2 + 2^(n+1) clocks after the write.
- R5: In 16-bit mode (control bit 6 = 1), a write to address 1 only loads a buffer. That buffer becomes the high byte at the next address-0 write. A read strobe at address 0 latches the current high byte, and address 1 then reads that latched value.
- R6: The flag (status bit 0) is set by rollover of the active width:
  - In 8-bit mode, by the low byte going from all ones to zero. The high byte is left unchanged.
  - In 16-bit mode, by the count going from FFFFh to 0000h.
  - A low-byte carry in 16-bit mode (for example 12FFh to 1300h) does not set the flag.
- R7: The flag is sticky.
  - It is cleared only by a write to address 3 with bit 0 = 0. Writing 1 to bit 0 never sets it.
  - A rollover in the same cycle as a clearing write leaves the flag set.
  - The interrupt output is high exactly when the flag and the enable (status bit 1) are both set. Clearing the enable leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_in | input | 1 | Asynchronous external count input |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe, used to latch the high byte on an address-0 read |
| addr | input | 2 | Register address (0 low count, 1 high count, 2 control, 3 status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register (combinational) |
| irq | output | 1 | Interrupt: flag AND enable |

## Verification
Two pairs of events can fall in the same clock: a count commit together with an increment, and a rollover together with a software write that clears the flag. The first pair is provoked by writing the count while the prescaler is bypassed, so an increment is due on every clock. It is judged by reading back exactly the written value, and then the same value for two more clocks. The second pair is provoked by loading all ones and timing the clearing status write to land on the third clock after the load. It is judged by the flag and the interrupt still being set afterwards.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   localparam int unsigned RATIO_W = 3;

   typedef enum logic [1:0] {
      A_CNT_LO = 2'd0,
      A_CNT_HI = 2'd1,
      A_CTRL   = 2'd2,
      A_STAT   = 2'd3
   } reg_addr_e;

   // bit 6 wide, bits 5:3 ratio, bit 2 bypass, bit 1 falling, bit 0 external
   typedef struct packed {
      logic               wide;
      logic [RATIO_W-1:0] ratio;
      logic               bypass;
      logic               fall;
      logic               ext;
   } ctrl_t;

endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic fall_i,
   output logic evt_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("evt_edge_sync: STAGES must be at least 2");
   end

   // chain[STAGES] holds the previous synchronised value for edge detection
   logic [STAGES:0] chain;

   for (genvar i = 0; i <= STAGES; i++) begin : g_chain
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= pin_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   logic rise_w, fall_w;
   assign rise_w = chain[STAGES-1] & ~chain[STAGES];
   assign fall_w = ~chain[STAGES-1] & chain[STAGES];
   assign evt_o  = fall_i ? fall_w : rise_w;

endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
   parameter int unsigned PS_W  = 8,
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_i,
   input  logic             clr_i,
   input  logic             hold_i,
   input  logic             bypass_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);

   if (PS_W != (1 << SEL_W)) begin : g_bad_width
      $error("evt_prescaler: PS_W must equal 2**SEL_W");
   end

   logic [PS_W-1:0] pre_q;
   logic [PS_W-1:0] low_ones;
   logic            adv;

   // low_ones[i] is set when bits i..0 are all ones; the next event wraps them
   for (genvar i = 0; i < PS_W; i++) begin : g_tap
      assign low_ones[i] = &pre_q[i:0];
   end

   assign adv = evt_i & ~hold_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pre_q <= '0;
      else if (clr_i)            pre_q <= '0;
      else if (adv && !bypass_i) pre_q <= pre_q + 1'b1;
   end

   assign tick_o = adv & (bypass_i | low_ones[sel_i]);

endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
   parameter int unsigned BW   = 8,
   parameter int unsigned HOLD = 2,
   localparam int unsigned CW     = 2 * BW,
   localparam int unsigned HOLD_W = $clog2(HOLD + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          wide_i,
   input  logic          ld_i,
   input  logic [CW-1:0] ld_val_i,
   output logic [CW-1:0] cnt_o,
   output logic          hold_o,
   output logic          ovf_o
);

   if (HOLD < 1) begin : g_bad_hold
      $error("evt_count_core: HOLD must be at least 1");
   end

   logic [CW-1:0]     cnt_q;
   logic [CW-1:0]     cnt_nxt;
   logic [BW-1:0]     lo_inc;
   logic [HOLD_W-1:0] hold_q;

   assign lo_inc  = cnt_q[BW-1:0] + BW'(1);
   assign cnt_nxt = wide_i ? (cnt_q + CW'(1)) : {cnt_q[CW-1:BW], lo_inc};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (ld_i)   cnt_q <= ld_val_i;
      else if (tick_i) cnt_q <= cnt_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              hold_q <= '0;
      else if (ld_i)           hold_q <= HOLD_W'(HOLD);
      else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
   end

   assign hold_o = (hold_q != '0);
   assign ovf_o  = tick_i & ~ld_i & (wide_i ? (&cnt_q) : (&cnt_q[BW-1:0]));
   assign cnt_o  = cnt_q;

endmodule

// File: rtl/evt_timer.sv
module evt_timer
   import evt_timer_pkg::*;
#(
   parameter int unsigned BW          = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PS_W        = 8,
   parameter int unsigned HOLD_CYC    = 2,
   localparam int unsigned CW         = 2 * BW,
   localparam int unsigned CTRL_W     = $bits(ctrl_t)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ext_in,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [1:0]    addr,
   input  logic [BW-1:0] wdata,
   output logic [BW-1:0] rdata,
   output logic          irq
);

   if (BW < CTRL_W) begin : g_bad_bw
      $error("evt_timer: BW too narrow for the control register");
   end
   if (PS_W != (1 << RATIO_W)) begin : g_bad_ps
      $error("evt_timer: PS_W must match the ratio field");
   end

   ctrl_t         ctrl_q;
   logic [BW-1:0] hbuf_q;
   logic [BW-1:0] rlat_q;
   logic          flag_q;
   logic          ien_q;

   logic          pin_evt, src_evt, tick_w, hold_w, ovf_w;
   logic          commit, ps_clr, wide_w;
   logic [CW-1:0] cnt_w;
   logic [CW-1:0] ld_val;

   assign wide_w  = ctrl_q.wide;
   assign commit  = wr_en && (addr == A_CNT_LO);
   assign ps_clr  = commit && !ctrl_q.bypass;
   assign ld_val  = wide_w ? {hbuf_q, wdata} : {cnt_w[CW-1:BW], wdata};
   assign src_evt = ctrl_q.ext ? pin_evt : 1'b1;

   evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (ext_in),
      .fall_i (ctrl_q.fall),
      .evt_o  (pin_evt)
   );

   evt_prescaler #(.PS_W(PS_W), .SEL_W(RATIO_W)) u_ps (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (src_evt),
      .clr_i    (ps_clr),
      .hold_i   (hold_w),
      .bypass_i (ctrl_q.bypass),
      .sel_i    (ctrl_q.ratio),
      .tick_o   (tick_w)
   );

   evt_count_core #(.BW(BW), .HOLD(HOLD_CYC)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_w),
      .wide_i   (wide_w),
      .ld_i     (commit),
      .ld_val_i (ld_val),
      .cnt_o    (cnt_w),
      .hold_o   (hold_w),
      .ovf_o    (ovf_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         hbuf_q <= '0;
         rlat_q <= '0;
         ien_q  <= 1'b0;
      end else begin
         if (wr_en && addr == A_CTRL)   ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
         if (wr_en && addr == A_CNT_HI) hbuf_q <= wdata;
         if (wr_en && addr == A_STAT)   ien_q  <= wdata[1];
         if (rd_en && addr == A_CNT_LO) rlat_q <= cnt_w[CW-1:BW];
      end
   end

   // set by rollover wins over a software clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                flag_q <= 1'b0;
      else if (ovf_w)                            flag_q <= 1'b1;
      else if (wr_en && addr == A_STAT && !wdata[0]) flag_q <= 1'b0;
   end

   always_comb begin
      case (addr)
         A_CNT_LO: rdata = cnt_w[BW-1:0];
         A_CNT_HI: rdata = rlat_q;
         A_CTRL:   rdata = BW'(ctrl_q);
         default:  rdata = BW'({ien_q, flag_q});
      endcase
   end

   assign irq = flag_q & ien_q;

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
   import evt_timer_pkg::*;
#(
   parameter int unsigned BW = 8,
   localparam int unsigned CW = 2 * BW
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [1:0]    addr,
   input logic [BW-1:0] wdata,
   input logic [CW-1:0] cnt,
   input logic          flag,
   input logic          wide
);

   logic commit;
   assign commit = wr_en && (addr == A_CNT_LO);

   // R4: the written low byte is what the count holds after the write
   a_r4_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> cnt[BW-1:0] == $past(wdata));

   // R4: first clock after a commit does not advance the count
   a_r4_hold_first: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(commit, 2) && !$past(commit)) |-> cnt == $past(cnt));

   // R4: second clock after a commit does not advance the count
   a_r4_hold_second: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(commit, 3) && !$past(commit, 2) && !$past(commit)) |-> cnt == $past(cnt));

   // R6: any change without a commit is a single step of the active width
   a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(commit) && cnt != $past(cnt)) |->
         ($past(wide) ? (cnt == CW'($past(cnt) + 1'b1))
                      : (cnt[CW-1:BW] == $past(cnt[CW-1:BW]) &&
                         cnt[BW-1:0] == BW'($past(cnt[BW-1:0]) + 1'b1))));

   // R6: a wrap of the active width raises the flag
   a_r6_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(commit) && $past(cnt[BW-1:0]) == '1 && cnt[BW-1:0] == '0 &&
       (!$past(wide) || $past(cnt[CW-1:BW]) == '1)) |-> flag);

   // R7: the flag only falls after a clearing status write
   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !(wr_en && addr == A_STAT && !wdata[0])) |=> flag);

endmodule

bind evt_timer evt_timer_chk #(.BW(BW)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .wr_en (wr_en),
   .addr  (addr),
   .wdata (wdata),
   .cnt   (cnt_w),
   .flag  (flag_q),
   .wide  (wide_w)
);

// File: tb/evt_timer_bench.sv
module evt_timer_bench;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_in = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   evt_timer u_evt_timer (
      .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] v);
      addr = a;
      #1 v = rdata;
   endtask

   task automatic rdlo(output logic [7:0] v);
      addr = 2'd0; rd_en = 1'b1;
      #1 v = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic pulse(input int hi, input int lo);
      ext_in = 1'b1; tick(hi);
      ext_in = 1'b0; tick(lo);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog act=%h exp=%h", 1'b0, 1'b1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      tick(3);
      // R1 reset state
      peek(0, v); chk("R1 count", v, 8'h00);
      peek(1, v); chk("R1 latch", v, 8'h00);
      peek(2, v); chk("R1 ctrl", v, 8'h00);
      peek(3, v); chk("R1 status", v, 8'h00);
      chk("R1 irq", irq, 1'b0);
      rst_n = 1'b1;
      tick(2);

      // R2 and R4: sweep all ratios plus bypass, timer mode, 8-bit
      for (int n = 0; n < 9; n++) begin
         int r;
         int cur;
         int ks[4];
         r = (n == 8) ? 1 : (1 << (n + 1));
         wr(2, (n == 8) ? 8'h04 : 8'(n << 3));
         wr(0, 8'h10);
         peek(0, v); chk("R4 load wins", v, 8'h10);
         ks = '{r + 1, r + 2, 3 * r + 1, 3 * r + 2};
         cur = 0;
         for (int j = 0; j < 4; j++) begin
            tick(ks[j] - cur);
            cur = ks[j];
            peek(0, v);
            chk("R2 R4 ratio sweep", v, 16'(8'h10 + (ks[j] - 2) / r));
         end
      end

      // R3 counter mode, rising edge, bypass
      wr(2, 8'h05); wr(0, 8'h00); tick(4);
      ext_in = 1'b1; tick(2);
      peek(0, v); chk("R3 no count before delay", v, 8'h00);
      tick(1);
      peek(0, v); chk("R3 count after three clocks", v, 8'h01);
      ext_in = 1'b0; tick(4);
      peek(0, v); chk("R3 falling ignored", v, 8'h01);
      // R3 falling edge select
      wr(2, 8'h07); tick(2);
      ext_in = 1'b1; tick(4);
      peek(0, v); chk("R3 rising ignored", v, 8'h01);
      ext_in = 1'b0; tick(2);
      peek(0, v); chk("R3 fall before delay", v, 8'h01);
      tick(1);
      peek(0, v); chk("R3 fall counted", v, 8'h02);
      tick(2);
      for (int i = 0; i < 5; i++) pulse(3, 3);
      peek(0, v); chk("R3 pulse train", v, 8'h07);
      // R3 with prescaler /4
      wr(2, 8'h09); wr(0, 8'h00); tick(3);
      for (int i = 0; i < 8; i++) pulse(2, 2);
      tick(2);
      peek(0, v); chk("R3 prescaled edges", v, 8'h02);

      // R6 R7 8-bit rollover
      wr(2, 8'h04); wr(3, 8'h00);
      wr(0, 8'hFE); tick(4);
      peek(0, v); chk("R6 8-bit wrap", v, 8'h00);
      peek(3, v); chk("R6 flag set", v, 8'h01);
      chk("R7 irq masked", irq, 1'b0);
      wr(3, 8'h03);
      peek(3, v); chk("R7 enable keeps flag", v, 8'h03);
      chk("R7 irq on", irq, 1'b1);
      wr(3, 8'h01);
      peek(3, v); chk("R7 disable keeps flag", v, 8'h01);
      chk("R7 irq off", irq, 1'b0);
      wr(3, 8'h00);
      peek(3, v); chk("R7 flag cleared", v, 8'h00);
      wr(3, 8'h01);
      peek(3, v); chk("R7 writing one no set", v, 8'h00);
      // R7 rollover and clearing write in the same clock
      wr(0, 8'hFF); tick(2);
      wr(3, 8'h02);
      peek(3, v); chk("R7 set beats clear", v, 8'h03);
      chk("R7 irq after collision", irq, 1'b1);
      wr(3, 8'h00);
      chk("R7 irq cleared", irq, 1'b0);

      // R5 R6 16-bit mode
      wr(2, 8'h44);
      wr(1, 8'h12);
      wr(0, 8'hFE); tick(4);
      rdlo(v); chk("R6 16-bit carry low", v, 8'h00);
      peek(1, v); chk("R5 latched high", v, 8'h13);
      peek(3, v); chk("R6 carry no flag", v, 8'h00);
      wr(1, 8'hFF);
      wr(0, 8'hFF); tick(3);
      rdlo(v); chk("R6 16-bit wrap low", v, 8'h00);
      peek(1, v); chk("R6 16-bit wrap high", v, 8'h00);
      peek(3, v); chk("R6 16-bit flag", v, 8'h01);
      // R6 8-bit wrap leaves high byte alone
      wr(3, 8'h00);
      wr(1, 8'h5A);
      wr(0, 8'hFD);
      wr(2, 8'h04);
      tick(4);
      rdlo(v); chk("R6 narrow wrap low", v, 8'h00);
      peek(1, v); chk("R6 narrow high kept", v, 8'h5A);
      peek(3, v); chk("R6 narrow flag", v, 8'h01);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule